// File: doc/BRIEF.md
# Strided address generator

This block supplies data-memory addresses to one edge processing element. It holds a small program of slots. Each slot pairs one control word with one address register. The control word makes the slot either constant or strided, and a strided slot also holds a stride value. A slot pointer selects the slot whose address register drives the address output. The output is combinational from the stored state.

The processing element raises a one-cycle trigger for each memory operation, taken from the trigger bit of its instruction. An accepted trigger uses the address already on the output. At the clock edge that ends that cycle, a strided slot adds its stride to its own register and the pointer moves to the next slot. When the pointer wraps from the last active slot back to slot 0, a pass counter increments.

The pass counter is compared against a preset pass limit only when the next trigger arrives. A trigger that finds the counter equal to the limit consumes nothing and sets a sticky done flag, so the last pass runs to completion before done is raised. A configuration port writes slots and separately loads the pass limit together with the index of the last active slot. Loading the limit also restarts the sequence.

Top module: `stride_agu`

## Requirements
- R1: After a synchronous active-low reset, every slot is constant with address 0 and stride 0, the pointer is at slot 0, the pass counter and pass limit are 0, the last active slot index is SLOTS-1, `done` is 0 and `addr_out` is 0.
- R2: A cycle with `cfg_we` high writes `cfg_mode`, `cfg_addr` and `cfg_stride` into slot `cfg_slot`. Mode encoding is 0 = constant, 1 = strided. `addr_out` always shows the address register of the slot under the pointer.
- R3: An accepted trigger on a constant slot leaves that slot's address register unchanged.
- R4: An accepted trigger on a strided slot presents the old address during the trigger cycle. The register then becomes old + stride, modulo 2^16.
- R5: Each accepted trigger moves the pointer forward by one slot, and from the last active slot it returns to slot 0. With no trigger, the pointer and all registers hold.
- R6: The pass counter increments when the pointer returns to slot 0. A trigger that arrives while the counter equals the pass limit sets `done` in the next cycle and changes neither the pointer nor any slot. With a limit of N and L+1 active slots, exactly N*(L+1) triggers are accepted before done.
- R7: Once `done` is 1, it stays 1 and triggers have no effect until reset or a limit load.
- R8: A cycle with `cfg_max_we` high loads `cfg_max` as the pass limit and `cfg_last` as the last active slot index. It also clears the pointer, the pass counter and `done`, and it leaves slot contents untouched.
- R9: A trigger in the same cycle as `cfg_we` or `cfg_max_we` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | IDX_W | Slot index to write |
| cfg_mode | input | 1 | 0 = constant, 1 = strided |
| cfg_addr | input | ADDR_W | Initial address for the slot |
| cfg_stride | input | ADDR_W | Stride for the slot |
| cfg_max_we | input | 1 | Load pass limit and last index, restart |
| cfg_max | input | CNT_W | Pass limit |
| cfg_last | input | IDX_W | Index of the last active slot |
| trig | input | 1 | Memory-operation trigger from the PE |
| addr_out | output | ADDR_W | Current data-memory address |
| done | output | 1 | End of execution, sticky |

## Verification
The main sequence runs a four-slot program of mixed constant and strided slots over two passes. It includes one strided slot that wraps past 0xFFFF, so the address seen in the first pass can be told apart from the incremented address in the second. This separates use-before-increment from increment-before-use and shows that constant slots are left alone. The ninth trigger must raise done without being consumed, which exposes an off-by-one in the delayed comparison. Directed cases cover the default zero limit after reset, a shortened two-slot program in which done freezes a strided slot, and a trigger that collides with a configuration write.

// File: rtl/stride_agu_pkg.sv
// Shared types for the strided address generator.
// Assumes: the mode field is one bit wide and is decoded only by the slot file.
package stride_agu_pkg;
    typedef enum logic {
        MODE_CONST   = 1'b0,
        MODE_STRIDED = 1'b1
    } slot_mode_e;

    // Slot control word: the mode plus the step added after each use.
    typedef struct packed {
        slot_mode_e  mode;
        logic [15:0] stride;
    } slot_ctrl_t;
endpackage

// File: rtl/stride_agu_slots.sv
// Slot file: one control word and one address register per slot.
// Drives the address of the selected slot combinationally. On a step, the
// selected slot adds its stride if it is strided. Assumes ADDR_W <= 16 for the
// stored stride field; a write and a step never arrive together (the sequencer
// blocks steps during configuration).
module stride_agu_slots
    import stride_agu_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_mode,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_stride,
    input  logic              step,
    input  logic [IDX_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] arf [SLOTS];
    slot_ctrl_t        cm  [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Hit flags for this slot.
        logic wr_hit, step_hit;
        assign wr_hit   = wr_en && (wr_idx == IDX_W'(i));
        assign step_hit = step && (sel == IDX_W'(i));

        // Control word: loaded by configuration only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cm[i].mode   <= MODE_CONST;
                cm[i].stride <= '0;
            end else if (wr_hit) begin
                cm[i].mode   <= slot_mode_e'(wr_mode);
                cm[i].stride <= 16'(wr_stride);
            end
        end

        // Address register: loaded by configuration, post-incremented on use.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arf[i] <= '0;
            end else if (wr_hit) begin
                arf[i] <= wr_addr;
            end else if (step_hit && cm[i].mode == MODE_STRIDED) begin
                arf[i] <= arf[i] + ADDR_W'(cm[i].stride);
            end
        end
    end

    // Present the selected slot's address.
    always_comb begin
        addr = arf[sel];
    end
endmodule

// File: rtl/stride_agu_seq.sv
// Sequencer: the slot pointer, the pass counter and the sticky done flag.
// A trigger is accepted only when no configuration is active, done is clear
// and the pass counter differs from the limit. A trigger that finds the
// counter equal to the limit sets done instead.
// Assumes: last_in < SLOTS.
module stride_agu_seq #(
    parameter int IDX_W = 2,
    parameter int CNT_W = 16,
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             hold,
    input  logic             restart,
    input  logic [CNT_W-1:0] max_in,
    input  logic [IDX_W-1:0] last_in,
    output logic [IDX_W-1:0] pc,
    output logic [IDX_W-1:0] last_q,
    output logic             fire,
    output logic             done
);
    logic [CNT_W-1:0] iter_q, max_q;
    logic             try_trig, at_limit, wrap;

    // Decode trigger outcome for this cycle.
    always_comb begin
        try_trig = trig && !hold && !done;
        at_limit = (iter_q == max_q);
        fire     = try_trig && !at_limit;
        wrap     = fire && (pc == last_q);
    end

    // Pointer: advance on an accepted trigger, wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pc <= '0;
        end else if (fire) begin
            pc <= wrap ? '0 : pc + IDX_W'(1);
        end
    end

    // Pass counter: counts completed passes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            iter_q <= '0;
        end else if (wrap) begin
            iter_q <= iter_q + CNT_W'(1);
        end
    end

    // Limit and program length: loaded on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q  <= '0;
            last_q <= IDX_W'(SLOTS - 1);
        end else if (restart) begin
            max_q  <= max_in;
            last_q <= last_in;
        end
    end

    // Done flag: set by a trigger at the limit, cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            done <= 1'b0;
        end else if (try_trig && at_limit) begin
            done <= 1'b1;
        end
    end
endmodule

// File: rtl/stride_agu.sv
// Top of the strided address generator. Joins the slot file and the
// sequencer. Configuration in a cycle blocks that cycle's trigger.
// Assumes: trig is a single-cycle pulse per memory operation.
module stride_agu
    import stride_agu_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_slot,
    input  logic              cfg_mode,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              cfg_max_we,
    input  logic [CNT_W-1:0]  cfg_max,
    input  logic [IDX_W-1:0]  cfg_last,
    input  logic              trig,
    output logic [ADDR_W-1:0] addr_out,
    output logic              done
);
    logic [IDX_W-1:0] pc, last_q;
    logic             fire, cfg_busy;

    // Any configuration activity blocks the trigger.
    assign cfg_busy = cfg_we || cfg_max_we;

    stride_agu_seq #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .SLOTS (SLOTS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .hold    (cfg_busy),
        .restart (cfg_max_we),
        .max_in  (cfg_max),
        .last_in (cfg_last),
        .pc      (pc),
        .last_q  (last_q),
        .fire    (fire),
        .done    (done)
    );

    stride_agu_slots #(
        .SLOTS  (SLOTS),
        .ADDR_W (ADDR_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_slot),
        .wr_mode   (cfg_mode),
        .wr_addr   (cfg_addr),
        .wr_stride (cfg_stride),
        .step      (fire),
        .sel       (pc),
        .addr      (addr_out)
    );
endmodule

// File: rtl/stride_agu_chk.sv
// Checker for the strided address generator, bound to the top module.
// Watches the ports plus the pointer and accept strobe.
module stride_agu_chk #(
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              cfg_we,
    input logic              cfg_max_we,
    input logic              done,
    input logic              fire,
    input logic [IDX_W-1:0]  pc,
    input logic [IDX_W-1:0]  last_q,
    input logic [ADDR_W-1:0] addr_out
);
    // R5: accepted trigger moves pointer by one, wrapping at the last slot.
    p_pc_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pc == (($past(pc) == $past(last_q)) ? '0 : $past(pc) + IDX_W'(1)));

    // R5: without trigger or configuration, pointer and address hold.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !cfg_we && !cfg_max_we) |=> ($stable(pc) && $stable(addr_out)));

    // R6: done rises only after a trigger.
    p_done_by_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(trig));

    // R7: done is sticky until a limit load.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_max_we) |=> done);

    // R7: while done, triggers change neither pointer nor address.
    p_done_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_we && !cfg_max_we) |=> ($stable(pc) && $stable(addr_out)));

    // R8: a limit load restarts the sequence.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_max_we |=> (pc == '0 && !done));

    // R9: configuration blocks acceptance.
    p_cfg_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || cfg_max_we) |-> !fire);
endmodule

bind stride_agu stride_agu_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .cfg_we     (cfg_we),
    .cfg_max_we (cfg_max_we),
    .done       (done),
    .fire       (fire),
    .pc         (pc),
    .last_q     (last_q),
    .addr_out   (addr_out)
);

// File: tb/stride_agu_tb.sv
module stride_agu_tb;
    localparam int SLOTS = 4, ADDR_W = 16, CNT_W = 16, IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0, cfg_mode = 1'b0, cfg_max_we = 1'b0, trig = 1'b0;
    logic [IDX_W-1:0]  cfg_slot = '0, cfg_last = '0;
    logic [ADDR_W-1:0] cfg_addr = '0, cfg_stride = '0;
    logic [CNT_W-1:0]  cfg_max = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              done;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    stride_agu #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_mode(cfg_mode), .cfg_addr(cfg_addr), .cfg_stride(cfg_stride),
        .cfg_max_we(cfg_max_we), .cfg_max(cfg_max), .cfg_last(cfg_last),
        .trig(trig), .addr_out(addr_out), .done(done)
    );

    // Vector: address expected on the output during the trigger,
    // done expected afterwards. Program: slot0 const 0x0100, slot1 strided
    // 0x0200 +4, slot2 strided 0xFFFE +3, slot3 const 0x0300; limit 2.
    typedef struct packed {
        logic [15:0] exp_addr;
        logic        exp_done;
    } vec_t;
    localparam vec_t VECS [10] = '{
        '{16'h0100, 1'b0}, '{16'h0200, 1'b0}, '{16'hFFFE, 1'b0}, '{16'h0300, 1'b0},
        '{16'h0100, 1'b0}, '{16'h0204, 1'b0}, '{16'h0001, 1'b0}, '{16'h0300, 1'b0},
        '{16'h0100, 1'b1}, '{16'h0100, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_slot(input int idx, input logic mode, input logic [15:0] a, input logic [15:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = IDX_W'(idx); cfg_mode = mode; cfg_addr = a; cfg_stride = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ld_max(input logic [15:0] m, input int last);
        @(negedge clk);
        cfg_max_we = 1'b1; cfg_max = m; cfg_last = IDX_W'(last);
        @(negedge clk);
        cfg_max_we = 1'b0;
    endtask

    // One trigger pulse; checks the address presented during it.
    task automatic pulse(input string req, input logic [15:0] exp_addr);
        @(negedge clk);
        chk(req, 32'(addr_out), 32'(exp_addr));
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 addr after reset", 32'(addr_out), 32'h0);
        chk("R1 done after reset", 32'(done), 32'h0);
        // R6: reset limit is 0, so the first trigger sets done.
        pulse("R6 addr at limit 0", 16'h0000);
        chk("R6 done with limit 0", 32'(done), 32'h1);

        wr_slot(0, 1'b0, 16'h0100, 16'h0009);
        wr_slot(1, 1'b1, 16'h0200, 16'h0004);
        wr_slot(2, 1'b1, 16'hFFFE, 16'h0003);
        wr_slot(3, 1'b0, 16'h0300, 16'h0000);
        chk("R7 done held over slot writes", 32'(done), 32'h1);
        ld_max(16'd2, 3);
        chk("R8 done cleared by limit load", 32'(done), 32'h0);
        chk("R2 slot0 on output", 32'(addr_out), 32'h0100);

        // R3 R4 R5 R6: two passes then the delayed limit check.
        for (int i = 0; i < 10; i++) begin
            pulse("R4/R5 vector addr", VECS[i].exp_addr);
            chk("R6/R7 vector done", 32'(done), 32'(VECS[i].exp_done));
        end

        // R5: idle cycles hold.
        ld_max(16'd1, 1);
        repeat (3) @(negedge clk);
        chk("R5 idle hold, R8 slots kept", 32'(addr_out), 32'h0100);

        // R7: done freezes a strided slot, two-slot program.
        wr_slot(0, 1'b1, 16'h0500, 16'h0010);
        ld_max(16'd1, 1);
        pulse("R4 slot0 first use", 16'h0500);
        pulse("R5 slot1 via last index 1", 16'h0208);
        chk("R5 wrap at last index 1", 32'(addr_out), 32'h0510);
        pulse("R6 limit trigger addr", 16'h0510);
        chk("R6 done after one pass", 32'(done), 32'h1);
        pulse("R7 ignored trigger addr", 16'h0510);
        chk("R7 still frozen", 32'(addr_out), 32'h0510);
        chk("R7 done stays", 32'(done), 32'h1);

        // R9: trigger colliding with a slot write is ignored.
        ld_max(16'd5, 1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'd3; cfg_mode = 1'b0; cfg_addr = 16'h0777; cfg_stride = '0;
        trig = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; trig = 1'b0;
        chk("R9 collided trigger ignored", 32'(addr_out), 32'h0510);
        pulse("R9 next trigger accepted", 16'h0510);
        chk("R9 pointer moved one slot", 32'(addr_out), 32'h020C);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule